// File: doc/BRIEF.md
# Byte-Addressed Memory Target on a Two-Wire Serial Bus, with Write Guard

The block answers as a target on an I2C bus and gives a bus master read and write access to an internal byte array. It runs on a system clock that is much faster than SCL. Both bus lines pass through two-flop synchronizers, and every bus event is found by comparing successive synchronized samples. The block never drives SDA high. It only asserts an active-high pull-low enable, `sda_oe_o`, and the pad or bench builds the wired-AND line from it.

A write transfer sends the ID byte with R/W = 0, then two address bytes (high byte first), then any number of data bytes. Each data byte is stored at the pointer, and the pointer then increments, wrapping from the top of the array to zero. A read transfer sends the ID byte with R/W = 1 and streams bytes out from the current pointer. A write that sets the address, followed by a repeated START and a read, gives a random read. A data byte aimed at the inclusive window `wp_lo_i..wp_hi_i` is answered with NACK and is not stored, and the target then stays off the bus until the next START or STOP.

States: `ST_IDLE` waits for START. `ST_GET_ID`, `ST_GET_AHI`, `ST_GET_ALO` and `ST_GET_DATA` shift in a byte. `ST_ACK_SLOT` holds the target's acknowledge, or a released line after a master ACK. `ST_SEND` shifts a byte out. `ST_MACK` samples the master's acknowledge. `ST_HALT` ignores the bus. The transitions are:
- START from any state goes to `ST_GET_ID`. STOP from any state goes to `ST_IDLE`.
- `ST_GET_ID` goes to `ST_ACK_SLOT` on an ID match, or to `ST_HALT` on a mismatch.
- `ST_GET_AHI` goes to `ST_ACK_SLOT`, then on to `ST_GET_ALO`.
- `ST_GET_ALO` goes to `ST_ACK_SLOT`, then on to `ST_GET_DATA`.
- `ST_GET_DATA` goes to `ST_ACK_SLOT` (and back to `ST_GET_DATA`), or to `ST_HALT` when the address is guarded.
- After an ID match with R/W = 1, `ST_ACK_SLOT` goes to `ST_SEND`.
- `ST_SEND` goes to `ST_MACK` after its eighth bit.
- `ST_MACK` goes to `ST_ACK_SLOT` (and then `ST_SEND`) on a master ACK, or to `ST_HALT` on a master NACK.

Top module: `i2c_mem_target`

## Requirements
- R1: `bus_busy_o` becomes 1 after a START (SDA falls while SCL is high) and becomes 0 after a STOP (SDA rises while SCL is high).
- R2: An ID byte whose upper 7 bits equal `TGT_ID` is acknowledged. Any other ID is answered with NACK, and later bytes are not acknowledged until the next START or STOP.
- R3: Bytes travel MSB first. The receiver pulls SDA low in the ninth clock to acknowledge, and the target releases SDA when that acknowledge clock ends.
- R4: In a write transfer the two bytes after the ID form a 16-bit address, high byte first, and its low `ADDR_W` bits load the pointer.
- R5: Each write data byte outside the guard window is stored at the pointer and acknowledged, and the pointer then increments.
- R6: A write data byte whose pointer lies in `wp_lo_i..wp_hi_i` (inclusive) gets NACK and is not stored. Further bytes get no acknowledge until the next START or STOP.
- R7: A read transfer drives the byte at the pointer, MSB first, and keeps sending consecutive bytes for as long as the master acknowledges.
- R8: After a master NACK the target keeps SDA released for every following clock until the next START or STOP.
- R9: A repeated START keeps `bus_busy_o` at 1 and returns the target to waiting for an ID byte.
- R10: A read with no address phase starts at the current pointer. The pointer increments after every transmitted byte, including the last one, which the master NACKs.
- R11: The pointer wraps from 2^`ADDR_W`-1 to 0 on both writes and reads.
- R12: `sda_oe_o` changes only while the synchronized SCL is low. After reset `sda_oe_o` = 0, `bus_busy_o` = 0, and every memory byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 = pull SDA low; 0 = release |
| bus_busy_o | output | 1 | Set between START and STOP |
| wp_lo_i | input | ADDR_W | Lowest guarded address |
| wp_hi_i | input | ADDR_W | Highest guarded address |

## Verification
The checks assume a well-formed master:
- SDA changes only while SCL is low, except at a START or a STOP.
- Each SCL level lasts longer than the synchronizer latency plus one system clock.
- The master never starts a transfer while the target is pulling SDA low.

The bench's bus tasks keep to these rules by construction. Every SCL or SDA change is separated from the next by eight system clocks. A repeated START or a STOP is issued only after the target has released the line, so reads always end with a master NACK. Under these assumptions, START and STOP can occur only with SCL high, and the target can change its pull-down only while SCL is low.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GET_ID,
        ST_GET_AHI,
        ST_GET_ALO,
        ST_GET_DATA,
        ST_ACK_SLOT,
        ST_SEND,
        ST_MACK,
        ST_HALT
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic line_q
);
    logic [STAGES-1:0] pipe;

    // Bus idles high, so reset the pipeline to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe   <= '1;
            line_q <= 1'b1;
        end else begin
            pipe   <= {pipe[STAGES-2:0], line_i};
            line_q <= pipe[STAGES-1];
        end
    end

    assign line_s = pipe[STAGES-1];
endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ID      = 7'h52,
    parameter int         ADDR_W      = 9,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              bus_busy_o,
    input  logic [ADDR_W-1:0] wp_lo_i,
    input  logic [ADDR_W-1:0] wp_hi_i
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_s, scl_q, sda_s, sda_q;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    tgt_state_t        state, state_n, ret_state, ret_n;
    logic [3:0]        bit_cnt;
    logic [7:0]        rx_sh, tx_sh;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] ptr;
    logic              oe, busy;
    logic              byte_done, id_hit, wr_blocked, mem_we;
    logic [7:0]        mem_rdata;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_s(scl_s), .line_q(scl_q)
    );
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_s(sda_s), .line_q(sda_q)
    );

    assign scl_rise   = scl_s & ~scl_q;
    assign scl_fall   = ~scl_s & scl_q;
    assign start_ev   = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev    = scl_s & scl_q & ~sda_q & sda_s;
    assign byte_done  = scl_fall && (bit_cnt == 4'd8);
    assign id_hit     = (rx_sh[7:1] == TGT_ID);
    assign wr_blocked = (ptr >= wp_lo_i) && (ptr <= wp_hi_i);
    assign mem_we     = (state == ST_GET_DATA) && byte_done && !wr_blocked;

    i2c_byte_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr), .wdata(rx_sh),
        .raddr(ptr), .rdata(mem_rdata)
    );

    // Next-state decision
    always_comb begin
        state_n = state;
        ret_n   = ret_state;
        if (start_ev) begin
            state_n = ST_GET_ID;
        end else if (stop_ev) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_GET_ID: if (byte_done) begin
                    state_n = id_hit ? ST_ACK_SLOT : ST_HALT;
                    ret_n   = rx_sh[0] ? ST_SEND : ST_GET_AHI;
                end
                ST_GET_AHI: if (byte_done) begin
                    state_n = ST_ACK_SLOT;
                    ret_n   = ST_GET_ALO;
                end
                ST_GET_ALO: if (byte_done) begin
                    state_n = ST_ACK_SLOT;
                    ret_n   = ST_GET_DATA;
                end
                ST_GET_DATA: if (byte_done) begin
                    state_n = wr_blocked ? ST_HALT : ST_ACK_SLOT;
                    ret_n   = ST_GET_DATA;
                end
                ST_ACK_SLOT: if (scl_fall) state_n = ret_state;
                ST_SEND:     if (scl_fall && bit_cnt == 4'd7) state_n = ST_MACK;
                ST_MACK: if (scl_rise) begin
                    state_n = sda_s ? ST_HALT : ST_ACK_SLOT;
                    ret_n   = ST_SEND;
                end
                ST_IDLE, ST_HALT: state_n = state;
                default:          state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ret_state <= ST_IDLE;
        end else begin
            state     <= state_n;
            ret_state <= ret_n;
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe      <= 1'b0;
            busy    <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            addr_hi <= '0;
            ptr     <= '0;
        end else if (start_ev) begin
            busy    <= 1'b1;
            oe      <= 1'b0;
            bit_cnt <= '0;
        end else if (stop_ev) begin
            busy    <= 1'b0;
            oe      <= 1'b0;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_GET_ID, ST_GET_AHI, ST_GET_ALO, ST_GET_DATA: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        oe      <= (state_n == ST_ACK_SLOT);
                        if (state == ST_GET_AHI) addr_hi <= rx_sh[HI_W-1:0];
                        if (state == ST_GET_ALO) ptr <= {addr_hi, rx_sh};
                        if (mem_we)              ptr <= ptr + 1'b1;
                    end
                end
                ST_ACK_SLOT: if (scl_fall) begin
                    bit_cnt <= '0;
                    if (ret_state == ST_SEND) begin
                        tx_sh <= mem_rdata;
                        oe    <= ~mem_rdata[7];
                    end else begin
                        oe    <= 1'b0;
                    end
                end
                ST_SEND: if (scl_fall) begin
                    if (bit_cnt == 4'd7) begin
                        oe  <= 1'b0;
                        ptr <= ptr + 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 4'd1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        oe      <= ~tx_sh[6];
                    end
                end
                ST_MACK: oe <= 1'b0;
                default: oe <= 1'b0;
            endcase
        end
    end

    assign sda_oe_o   = oe;
    assign bus_busy_o = busy;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              sda_oe_o,
    input logic              bus_busy_o,
    input logic              mem_we,
    input logic [ADDR_W-1:0] ptr,
    input logic [ADDR_W-1:0] wp_lo_i,
    input logic [ADDR_W-1:0] wp_hi_i,
    input tgt_state_t        state
);
    assert_busy_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> bus_busy_o);

    assert_busy_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !bus_busy_o);

    assert_restart_to_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_GET_ID));

    assert_guard_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !((ptr >= wp_lo_i) && (ptr <= wp_hi_i)));

    assert_halt_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> !sda_oe_o);

    assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_oe_o(sda_oe_o), .bus_busy_o(bus_busy_o), .mem_we(mem_we), .ptr(ptr),
    .wp_lo_i(wp_lo_i), .wp_hi_i(wp_hi_i), .state(state)
);

// File: tb/test_i2c_mem_target.sv
`timescale 1ns/1ps
module test_i2c_mem_target;
    localparam logic [6:0] ID = 7'h52;
    localparam int         AW = 9;
    localparam int         Q  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, busy, sda_line;
    int   n_chk = 0;
    int   n_err = 0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_mem_target #(.TGT_ID(ID), .ADDR_W(AW), .SYNC_STAGES(2)) i_i2c_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .bus_busy_o(busy),
        .wp_lo_i(9'h040), .wp_hi_i(9'h04F)
    );

    // {16-bit address, data}
    localparam logic [23:0] VEC [6] = '{
        24'h0005A5, 24'h00C33C, 24'h0100FF, 24'h01AB81, 24'hFE106E, 24'h017E5A
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nak);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); nak = sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
        end
        sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
    endtask

    task automatic open_write(input logic [15:0] a, output int naks);
        logic n;
        naks = 0;
        bus_start();
        send_byte({ID, 1'b0}, n); naks += int'(n);
        send_byte(a[15:8], n);    naks += int'(n);
        send_byte(a[7:0], n);     naks += int'(n);
    endtask

    task automatic open_read_at(input logic [15:0] a, output int naks);
        logic n;
        open_write(a, naks);
        bus_start();
        check("R9 busy held over repeated START", 16'(busy), 16'd1);
        send_byte({ID, 1'b1}, n); naks += int'(n);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int naks;
        logic n;
        logic [7:0] b;

        repeat (4) @(negedge clk);
        check("R12 reset oe", 16'(sda_oe), 16'd0);
        check("R1 reset busy", 16'(busy), 16'd0);
        rst_n = 1'b1;
        wq();

        // R12: memory resets to zero
        open_read_at(16'h0030, naks);
        recv_byte(1'b0, b);
        bus_stop();
        check("R12 reset memory byte", 16'(b), 16'h00);

        // Table walk: single write then random read (R4, R5, R7, R3)
        for (int k = 0; k < 6; k++) begin
            open_write(VEC[k][23:8], naks);
            send_byte(VEC[k][7:0], n);
            bus_stop();
            check("R5 write acks", 16'(naks + int'(n)), 16'd0);
            open_read_at({7'd0, VEC[k][16:8]}, naks);
            recv_byte(1'b0, b);
            bus_stop();
            check("R4 R7 readback", 16'(b), 16'(VEC[k][7:0]));
            check("R2 ID ack on read", 16'(naks), 16'd0);
        end

        // R1: busy flag
        bus_start();
        check("R1 busy after START", 16'(busy), 16'd1);
        send_byte({ID ^ 7'h01, 1'b0}, n);
        check("R2 wrong ID nack", 16'(n), 16'd1);
        send_byte(8'h00, n);
        check("R2 ignored after mismatch", 16'(n), 16'd1);
        bus_stop();
        check("R1 busy after STOP", 16'(busy), 16'd0);

        // Streaming write, then sequential and current-address reads
        open_write(16'h0020, naks);
        send_byte(8'h11, n); naks += int'(n);
        check("R3 released after ack", 16'(sda_line), 16'd1);
        send_byte(8'h22, n); naks += int'(n);
        send_byte(8'h33, n); naks += int'(n);
        send_byte(8'h44, n); naks += int'(n);
        bus_stop();
        check("R5 stream acks", 16'(naks), 16'd0);
        open_read_at(16'h0020, naks);
        recv_byte(1'b1, b); check("R7 seq byte 0", 16'(b), 16'h11);
        recv_byte(1'b1, b); check("R7 seq byte 1", 16'(b), 16'h22);
        recv_byte(1'b0, b); check("R7 seq byte 2", 16'(b), 16'h33);
        bus_stop();
        bus_start();
        send_byte({ID, 1'b1}, n);
        recv_byte(1'b0, b);
        bus_stop();
        check("R10 current-address read", 16'(b), 16'h44);

        // Guarded window 0x040..0x04F
        open_write(16'h003E, naks);
        send_byte(8'hC1, n); naks += int'(n);
        send_byte(8'hC2, n); naks += int'(n);
        check("R6 unguarded acks", 16'(naks), 16'd0);
        send_byte(8'hC3, n);
        check("R6 guarded nack", 16'(n), 16'd1);
        send_byte(8'hC4, n);
        check("R6 ignored after guard", 16'(n), 16'd1);
        bus_stop();
        open_read_at(16'h003E, naks);
        recv_byte(1'b1, b); check("R6 byte before guard", 16'(b), 16'hC1);
        recv_byte(1'b1, b); check("R6 byte before guard 2", 16'(b), 16'hC2);
        recv_byte(1'b1, b); check("R6 guarded not stored", 16'(b), 16'h00);
        recv_byte(1'b0, b); check("R6 next not stored", 16'(b), 16'h00);
        bus_stop();

        // Wrap at top of array
        open_write(16'h01FF, naks);
        send_byte(8'h77, n); naks += int'(n);
        send_byte(8'h88, n); naks += int'(n);
        bus_stop();
        check("R11 wrap write acks", 16'(naks), 16'd0);
        open_read_at(16'h01FF, naks);
        recv_byte(1'b1, b); check("R11 top byte", 16'(b), 16'h77);
        recv_byte(1'b0, b); check("R11 wrapped byte", 16'(b), 16'h88);
        bus_stop();
        open_read_at(16'h0000, naks);
        recv_byte(1'b0, b);
        bus_stop();
        check("R11 byte at zero", 16'(b), 16'h88);

        // Master NACK: target stays released
        bus_start();
        send_byte({ID, 1'b1}, n);
        recv_byte(1'b0, b);
        recv_byte(1'b0, b);
        check("R8 released after master NACK", 16'(b), 16'hFF);
        bus_stop();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule